// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Arbiter

This block gathers level-sensitive request lines from peripherals, one per maskable vector, and selects one winner to present to the processor. Each source has a software-set 3-bit priority level. Level 0 keeps a source silent. Among pending sources, the highest level wins. When several sources share that level, the lowest vector number wins.

The winner is forwarded only when its level is strictly above the processor's current interrupt level. The block drives a request flag, the winning level, the winning vector number and the handler fetch address. The fetch address is a 1 KB-aligned table base plus four times the vector number. A small register port sets and reads back the per-source levels and the table base. The arbitration result is registered, so the outputs follow the inputs one clock later.

Top module: `irq_arbiter`

## Requirements
- R1: There are 29 request lines. Line i belongs to vector number 16+i, so line 0 is vector 16 and line 28 is vector 44.
- R2: After reset, every level register and the table base are 0 and `int_req` is low.
- R3: A source whose level is 0 never produces a request, even while its line is high.
- R4: Among pending sources with non-zero level, the one with the highest level wins. `int_level` carries that level.
- R5: When several pending sources share the highest level, the one with the lowest vector number wins.
- R6: Requests are level-sensitive. The request stays presented for as long as the line stays high. It is withdrawn after the line drops and no other eligible source remains.
- R7: `int_addr` equals the table base plus 4 × `int_vector`. For example, vector 40 gives base + 0xA0.
- R8: Table base register (offset 31): write bits 9:0 are ignored and read back as 0. The upper bits are stored as written.
- R9: A winner is presented only if its level is strictly greater than `cpu_level`. If the winner's level is equal or lower, `int_req` is low.
- R10: Register offsets 0..28 hold the level of line 0..28 in bits 2:0. Only those bits are stored, and each level reads back. Offsets 29 and 30 read 0.
- R11: Outputs are registered. A change on the lines, levels or `cpu_level` appears one clock later. While idle, `int_level`, `int_vector` and `int_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 29 | Level request per source, bit i = vector 16+i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| cpu_level | input | 3 | Processor's current interrupt level |
| int_req | output | 1 | Interrupt request to processor |
| int_level | output | 3 | Level of the presented request |
| int_vector | output | 6 | Vector number of the presented request |
| int_addr | output | 32 | Handler fetch address |

## Verification
The tests first raise every line while all levels are still 0, to show that level 0 masks a source. They then raise sources with distinct levels, which separates "highest level wins" from "lowest index wins". Next, several sources share one level, which exercises the vector-number tie-break. The processor level is swept across the winner's level, and equality tells a strict from a non-strict comparison. Finally, a line is held and then dropped while its output is sampled on both sides of a clock edge. This shows the level-sensitive behaviour and the one-cycle latency. Base writes with the low bits set check the masking of bits 9:0 and the address arithmetic.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC    = 29,
  parameter int FIRST_VEC  = 16,
  parameter int LVL_W      = 3,
  parameter int ADDR_W     = 32,
  parameter int BASE_ALIGN = 10,
  parameter int REG_AW     = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0]               irq_lines,
  input  logic                             reg_we,
  input  logic [REG_AW-1:0]                reg_addr,
  input  logic [ADDR_W-1:0]                reg_wdata,
  output logic [ADDR_W-1:0]                reg_rdata,
  input  logic [LVL_W-1:0]                 cpu_level,
  output logic                             int_req,
  output logic [LVL_W-1:0]                 int_level,
  output logic [$clog2(FIRST_VEC+NUM_SRC)-1:0] int_vector,
  output logic [ADDR_W-1:0]                int_addr
);
  localparam int VEC_W    = $clog2(FIRST_VEC + NUM_SRC);
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int HI_W     = ADDR_W - BASE_ALIGN;
  localparam int BASE_OFS = (1 << REG_AW) - 1;

  logic [LVL_W-1:0] lvl_q [NUM_SRC];
  logic [HI_W-1:0]  base_hi;
  logic [ADDR_W-1:0] base_full;
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;
  logic             eligible;
  logic [VEC_W-1:0] win_vec;

  assign base_full = {base_hi, {BASE_ALIGN{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
      base_hi <= '0;
    end else if (reg_we) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (reg_addr == REG_AW'(i)) lvl_q[i] <= reg_wdata[LVL_W-1:0];
      if (reg_addr == REG_AW'(BASE_OFS)) base_hi <= reg_wdata[ADDR_W-1:BASE_ALIGN];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (reg_addr == REG_AW'(i)) reg_rdata = {{(ADDR_W-LVL_W){1'b0}}, lvl_q[i]};
    if (reg_addr == REG_AW'(BASE_OFS)) reg_rdata = base_full;
  end

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (irq_lines[i] && lvl_q[i] != '0 && lvl_q[i] >= best_lvl) begin
        best_lvl = lvl_q[i];
        best_idx = IDX_W'(i);
      end
  end

  assign eligible = (best_lvl != '0) && (best_lvl > cpu_level);
  assign win_vec  = VEC_W'(FIRST_VEC) + VEC_W'(best_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_req    <= 1'b0;
      int_level  <= '0;
      int_vector <= '0;
      int_addr   <= '0;
    end else begin
      int_req    <= eligible;
      int_level  <= eligible ? best_lvl : '0;
      int_vector <= eligible ? win_vec : '0;
      int_addr   <= eligible ? base_full + {{(ADDR_W-VEC_W-2){1'b0}}, win_vec, 2'b00} : '0;
    end
  end

  a_r3_no_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_level != '0);
  a_r9_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_level > $past(cpu_level));
  a_r6_line_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (($past(irq_lines) >> (int_vector - VEC_W'(FIRST_VEC))) & 1) != 0);
  a_r1_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (int_vector >= VEC_W'(FIRST_VEC)) && (int_vector < VEC_W'(FIRST_VEC + NUM_SRC)));
  a_r7_addr_low: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_addr[BASE_ALIGN-1:0] == BASE_ALIGN'({int_vector, 2'b00}));
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !int_req |-> (int_level == '0 && int_vector == '0 && int_addr == '0));
endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  logic        clk = 0, rst_n = 0;
  logic [28:0] irq_lines = '0;
  logic        reg_we = 0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [2:0]  cpu_level = '0, int_level;
  logic        int_req;
  logic [5:0]  int_vector;
  logic [31:0] int_addr;
  int checks = 0, fails = 0;

  irq_arbiter dut (.clk, .rst_n, .irq_lines, .reg_we, .reg_addr, .reg_wdata,
    .reg_rdata, .cpu_level, .int_req, .int_level, .int_vector, .int_addr);

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic settle; repeat (2) @(negedge clk); endtask

  task automatic expect_out(string req, logic r, logic [2:0] l, logic [5:0] v, logic [31:0] ad);
    chk(req, int_req, r); chk(req, int_level, l); chk(req, int_vector, v); chk(req, int_addr, ad);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    expect_out("R2", 0, 0, 0, 0);
    for (int i = 0; i < 29; i++) begin rd(i[4:0], d); chk("R2", d, 0); end
    rd(31, d); chk("R2", d, 0);
  endtask

  task automatic t_zero_mask;
    @(negedge clk); irq_lines = '1; settle();
    expect_out("R3", 0, 0, 0, 0);
    irq_lines = '0;
  endtask

  task automatic t_priority;
    wr(5, 2); wr(10, 4); wr(20, 6);
    @(negedge clk); irq_lines = (29'd1 << 5) | (29'd1 << 10) | (29'd1 << 20); settle();
    expect_out("R4", 1, 6, 36, 36 * 4);
    irq_lines[20] = 0; settle();
    expect_out("R4", 1, 4, 26, 26 * 4);
    irq_lines = '0; settle();
  endtask

  task automatic t_tie;
    wr(3, 5); wr(7, 5); wr(12, 5);
    @(negedge clk); irq_lines = (29'd1 << 12) | (29'd1 << 7) | (29'd1 << 3); settle();
    expect_out("R5", 1, 5, 19, 19 * 4);
    irq_lines[3] = 0; settle();
    expect_out("R5", 1, 5, 23, 23 * 4);
  endtask

  task automatic t_cpu_level;
    @(negedge clk); cpu_level = 5; settle();
    chk("R9 equal level blocked", int_req, 0);
    cpu_level = 7; settle();
    chk("R9 higher cpu blocked", int_req, 0);
    cpu_level = 4; settle();
    chk("R9 strictly above", int_req, 1);
    chk("R9", int_vector, 23);
    cpu_level = 0; irq_lines = '0; settle();
  endtask

  task automatic t_base;
    logic [31:0] d;
    wr(31, 32'h0001_23FF);
    rd(31, d); chk("R8", d, 32'h0001_2000);
    wr(24, 1);
    @(negedge clk); irq_lines = 29'd1 << 24; settle();
    expect_out("R7", 1, 1, 40, 32'h0001_20A0);
    irq_lines = 29'd1 << 28; wr(28, 3); settle();
    expect_out("R1", 1, 3, 44, 32'h0001_2000 + 44 * 4);
    wr(0, 7); irq_lines = 29'd1; settle();
    expect_out("R1", 1, 7, 16, 32'h0001_2040);
    irq_lines = '0; settle();
  endtask

  task automatic t_level_latency;
    @(negedge clk); irq_lines = 29'd1 << 10; #1;
    chk("R11 before edge", int_req, 0);
    @(negedge clk);
    chk("R11 after edge", int_req, 1);
    chk("R11", int_vector, 26);
    repeat (5) @(negedge clk);
    chk("R6 held", int_req, 1);
    irq_lines = '0; #1;
    chk("R11 drop before edge", int_req, 1);
    @(negedge clk);
    expect_out("R6", 0, 0, 0, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(2, 32'hFF);
    rd(2, d); chk("R10", d, 7);
    rd(10, d); chk("R10", d, 4);
    wr(29, 32'hFFFF_FFFF);
    rd(29, d); chk("R10", d, 0);
    rd(30, d); chk("R10", d, 0);
    rd(31, d); chk("R10", d, 32'h0001_2000);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero_mask();
    t_priority();
    t_tie();
    t_cpu_level();
    t_base();
    t_level_latency();
    t_regmap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule